// File: doc/BRIEF.md
# Full-Rate Two-to-One Serializer

This block interleaves two parallel bit lanes into a single stream that carries one bit per period of its only clock, the full-rate clock. A divide-by-two inside the block produces a half-rate phase. That phase is driven out to the lane source, so the source knows when its words are captured. Each lane is retimed through a master/slave latch pair on the half-rate phase. The second lane passes through one more half-phase stage, so both lanes are stable at different times.

A delayed copy of the phase steers a two-way selector between the lanes. A flip-flop on the full-rate clock then regenerates the selected bit. Each output bit therefore lasts exactly one clock period, whatever the shape of the half-rate phase. A marker output rises once the pipeline holds real data, so a source-synchronous receiver that uses the same clock knows when to start capturing. The `WIDTH` parameter sets how many independent bit slices are built side by side.

Top module: `ser2_full_rate`

## Requirements
- R1: While `rst_i` is sampled high at a rising clock edge, that edge sets `ser_o` to all zeros, `fwd_en_o` to 0 and `half_clk_o` to 0.
- R2: After reset is released, `half_clk_o` inverts on every rising clock edge. It goes from 0 to 1 at the first edge, so it is 1 after the edges numbered 0, 2, 4 and so on (edge 0 is the first edge with `rst_i` low).
- R3: A lane pair is captured only at edges where `half_clk_o` is 0 just before the edge, which are the even-numbered edges. Lane values present at odd-numbered edges have no effect on `ser_o`.
- R4: The lane-0 word of a pair captured at edge n appears on `ser_o` after edge n+2.
- R5: The lane-1 word of the same pair appears on `ser_o` after edge n+3, directly after its lane-0 word. Within each pair, lane 0 is always sent first.
- R6: `fwd_en_o` is 0 until edge 2 and becomes 1 after edge 2, which is a fixed pipeline latency of 2 edges. It then stays at 1 until the next reset.
- R7: Bit i of `ser_o` depends only on bit i of `lane0_i` and bit i of `lane1_i`. The slices are independent of each other.
- R8: Asserting `rst_i` in the middle of a stream returns all outputs to the R1 state at the next edge, discarding any data that is still in flight.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Full-rate clock |
| rst_i | input | 1 | Synchronous reset, active high |
| lane0_i | input | WIDTH | First lane word, sent first in each pair |
| lane1_i | input | WIDTH | Second lane word, sent second in each pair |
| ser_o | output | WIDTH | Serial output, one bit per slice per clock period |
| half_clk_o | output | 1 | Half-rate phase sent to the lane source; 0 marks a capture edge |
| fwd_en_o | output | 1 | Marker that the serial output holds valid data |

## Verification
The assertions assume that the lane source follows `half_clk_o`. They relate the serial output to the lane values seen at capture edges, two and three edges earlier, and they say nothing about values present at odd edges. The stimulus changes the lanes only half a period away from the rising edge. It places each new pair before an even edge and, in one scenario, deliberately scrambles the lanes before odd edges to show those values are discarded. A reset in the middle of a stream also cuts short any pending assertion window.

// File: rtl/ser2_pkg.sv
package ser2_pkg;

   // Edges between the capture of a lane pair and the appearance of its first bit.
   localparam int unsigned SER2_PIPE_LAT = 2;

   // Meaning of the half-rate phase just before a rising edge.
   typedef enum logic {
      PH_CAPTURE  = 1'b0,
      PH_TRANSFER = 1'b1
   } ser2_phase_e;

endpackage

// File: rtl/ser2_phase_gen.sv
module ser2_phase_gen
   import ser2_pkg::*;
#(
   parameter int unsigned PIPE_LAT = SER2_PIPE_LAT
) (
   input  logic clk_i,
   input  logic rst_i,
   output logic half_o,
   output logic dly_o,
   output logic vld_o
);

   localparam int unsigned CNT_W = $clog2(PIPE_LAT + 1);
   localparam logic [CNT_W-1:0] LAT_C = CNT_W'(PIPE_LAT);

   if (PIPE_LAT != SER2_PIPE_LAT) begin : g_bad_lat
      $error("ser2_phase_gen: PIPE_LAT must match the fixed datapath depth");
   end

   logic             half_q;
   logic             dly_q;
   logic             vld_q;
   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         half_q <= 1'b0;
         dly_q  <= 1'b0;
         vld_q  <= 1'b0;
         cnt_q  <= '0;
      end else begin
         half_q <= ~half_q;
         dly_q  <= half_q;
         if (cnt_q != LAT_C) begin
            cnt_q <= cnt_q + 1'b1;
         end
         vld_q <= vld_q | (cnt_q == LAT_C);
      end
   end

   assign half_o = half_q;
   assign dly_o  = dly_q;
   assign vld_o  = vld_q;

   // R2
   half_toggle_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      !rst_i |=> (half_q != $past(half_q)));

   // R2
   dly_phase_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      !rst_i |=> (dly_q != half_q));

   // R6
   vld_sticky_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      vld_q |=> vld_q);

   // R6
   vld_rise_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      $rose(vld_q) |-> (cnt_q == LAT_C));

endmodule

// File: rtl/ser2_lane_slice.sv
module ser2_lane_slice
   import ser2_pkg::*;
(
   input  logic clk_i,
   input  logic rst_i,
   input  logic half_i,
   input  logic dly_i,
   input  logic lane0_i,
   input  logic lane1_i,
   output logic ser_o
);

   ser2_phase_e ph;
   assign ph = ser2_phase_e'(half_i);

   logic mst0_q, mst1_q;
   logic slv0_q, slv1_q;
   logic ext1_q;
   logic pick;
   logic dec_q;

   // Master stage: take the lane pair on capture edges.
   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         mst0_q <= 1'b0;
         mst1_q <= 1'b0;
      end else if (ph == PH_CAPTURE) begin
         mst0_q <= lane0_i;
         mst1_q <= lane1_i;
      end
   end

   // Slave stage: pass master content on transfer edges.
   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         slv0_q <= 1'b0;
         slv1_q <= 1'b0;
      end else if (ph == PH_TRANSFER) begin
         slv0_q <= mst0_q;
         slv1_q <= mst1_q;
      end
   end

   // Extra half-phase stage on the second lane only.
   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         ext1_q <= 1'b0;
      end else if (ph == PH_CAPTURE) begin
         ext1_q <= slv1_q;
      end
   end

   // Selector steered by the delayed phase, switching while both inputs are stable.
   always_comb begin
      pick = dly_i ? slv0_q : ext1_q;
   end

   // Full-rate decision flip-flop.
   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         dec_q <= 1'b0;
      end else begin
         dec_q <= pick;
      end
   end

   assign ser_o = dec_q;

   // R4
   first_bit_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      (half_i == 1'b0) |=> ##2 (dec_q == $past(lane0_i, 3)));

   // R5
   second_bit_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      (half_i == 1'b0) |=> ##3 (dec_q == $past(lane1_i, 4)));

endmodule

// File: rtl/ser2_full_rate.sv
module ser2_full_rate
   import ser2_pkg::*;
#(
   parameter int unsigned WIDTH = 4
) (
   input  logic             clk_i,
   input  logic             rst_i,
   input  logic [WIDTH-1:0] lane0_i,
   input  logic [WIDTH-1:0] lane1_i,
   output logic [WIDTH-1:0] ser_o,
   output logic             half_clk_o,
   output logic             fwd_en_o
);

   if (WIDTH < 1) begin : g_bad_width
      $error("ser2_full_rate: WIDTH must be at least 1");
   end

   logic half;
   logic dly;
   logic vld;

   ser2_phase_gen #(
      .PIPE_LAT (SER2_PIPE_LAT)
   ) i_phase (
      .clk_i  (clk_i),
      .rst_i  (rst_i),
      .half_o (half),
      .dly_o  (dly),
      .vld_o  (vld)
   );

   for (genvar b = 0; b < WIDTH; b++) begin : g_slice
      ser2_lane_slice i_slice (
         .clk_i   (clk_i),
         .rst_i   (rst_i),
         .half_i  (half),
         .dly_i   (dly),
         .lane0_i (lane0_i[b]),
         .lane1_i (lane1_i[b]),
         .ser_o   (ser_o[b])
      );
   end

   assign half_clk_o = half;
   assign fwd_en_o   = vld;

   // R1
   reset_state_chk: assert property (@(posedge clk_i)
      rst_i |=> ((ser_o == '0) && !fwd_en_o && !half_clk_o));

   // R6
   marker_phase_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      $rose(fwd_en_o) |-> half_clk_o);

endmodule

// File: tb/test_ser2_full_rate.sv
module test_ser2_full_rate;

   localparam int unsigned W = 4;

   logic         clk = 1'b0;
   logic         rst = 1'b1;
   logic [W-1:0] lane0 = '0;
   logic [W-1:0] lane1 = '0;
   logic [W-1:0] ser;
   logic         half_clk;
   logic         fwd_en;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   always #5 clk = ~clk;

   ser2_full_rate #(.WIDTH(W)) i_ser2_full_rate (
      .clk_i      (clk),
      .rst_i      (rst),
      .lane0_i    (lane0),
      .lane1_i    (lane1),
      .ser_o      (ser),
      .half_clk_o (half_clk),
      .fwd_en_o   (fwd_en)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst = 1'b1;
      repeat (2) @(negedge clk);
      rst = 1'b0;
   endtask

   // R1: outputs after reset edges
   task automatic test_reset();
      @(negedge clk);
      rst = 1'b1;
      lane0 = '1;
      lane1 = '1;
      repeat (3) @(negedge clk);
      chk("R1 ser", 32'(ser), 32'h0);
      chk("R1 fwd_en", 32'(fwd_en), 32'h0);
      chk("R1 half_clk", 32'(half_clk), 32'h0);
      rst = 1'b0;
   endtask

   // mode 0: random pairs; mode 1: random, scrambled before odd edges (R3);
   // mode 2: fixed corner patterns.
   task automatic run_stream(input int n, input int mode);
      logic [W-1:0] l0 [16];
      logic [W-1:0] l1 [16];
      for (int k = 0; k < n; k++) begin
         if (mode == 2) begin
            l0[k] = ((k % 4) == 1 || (k % 4) == 2) ? '1 : '0;
            l1[k] = ((k % 4) == 1 || (k % 4) == 3) ? '1 : '0;
         end else begin
            l0[k] = W'($urandom);
            l1[k] = W'($urandom);
         end
      end
      do_reset();
      for (int e = 0; e <= 2 * n + 1; e++) begin
         if ((e % 2) == 0 && (e / 2) < n) begin
            lane0 = l0[e / 2];
            lane1 = l1[e / 2];
         end else if (mode == 1) begin
            lane0 = W'($urandom);
            lane1 = W'($urandom);
         end
         @(negedge clk);
         chk("R2 half_clk", 32'(half_clk), 32'((e % 2) == 0));
         chk("R6 fwd_en", 32'(fwd_en), 32'(e >= 2));
         if (e >= 2) begin
            if ((e % 2) == 0) begin
               chk(mode == 1 ? "R3/R4 lane0 word" : "R4 lane0 word", 32'(ser), 32'(l0[(e - 2) / 2]));
            end else begin
               chk(mode == 1 ? "R3/R5 lane1 word" : "R5 lane1 word", 32'(ser), 32'(l1[(e - 2) / 2]));
            end
         end
      end
   endtask

   // R7: a single set bit per lane reaches only its own slice
   task automatic test_slices();
      for (int b = 0; b < W; b++) begin
         do_reset();
         lane0 = W'(1) << b;
         lane1 = W'(1) << ((b + 1) % W);
         repeat (3) @(negedge clk);
         chk("R7 slice lane0", 32'(ser), 32'(W'(1) << b));
         @(negedge clk);
         chk("R7 slice lane1", 32'(ser), 32'(W'(1) << ((b + 1) % W)));
      end
   endtask

   // R8: reset in mid-stream
   task automatic test_mid_reset();
      do_reset();
      lane0 = '1;
      lane1 = '1;
      repeat (5) @(negedge clk);
      chk("R8 pre ser", 32'(ser), 32'({W{1'b1}}));
      rst = 1'b1;
      @(negedge clk);
      chk("R8 ser", 32'(ser), 32'h0);
      chk("R8 fwd_en", 32'(fwd_en), 32'h0);
      chk("R8 half_clk", 32'(half_clk), 32'h0);
      rst = 1'b0;
      lane0 = '0;
      lane1 = '0;
      @(negedge clk);
      chk("R8 restart half_clk", 32'(half_clk), 32'h1);
      chk("R8 restart fwd_en", 32'(fwd_en), 32'h0);
   endtask

   initial begin
      test_reset();
      run_stream(12, 0);
      run_stream(12, 1);
      run_stream(8, 2);
      test_slices();
      test_mid_reset();
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual hung expected done");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

endmodule